// File: doc/BRIEF.md
# Low-Power PWM Timer

A register-programmed timer that generates pulse-width modulated outputs. A power-of-two prescaler divides the clock into ticks. Each tick advances an up-counter that wraps after it reaches a programmed period limit. The block has two build variants. In the two-channel variant, both channels share the prescaler and the period. Each channel has its own compare value, enable bit and polarity bit. In the single-output variant, one waveform is driven and its polarity comes from a global bit in the configuration register.

Software drives the block through a small synchronous register bus. Every write lands in a single cycle, and read data is combinational. A three-state machine controls the timer. `ST_OFF` means the timer is disabled. `ST_ARMED` means the timer is enabled and the counter is held at zero. `ST_RUN` means the timer is counting continuously. Three transitions connect the states. `T_ENABLE` moves `ST_OFF` to `ST_ARMED`. `T_START` moves `ST_ARMED` to `ST_RUN`. `T_STOP` moves either enabled state back to `ST_OFF`.

Which writes are accepted depends on the state. Configuration can be written only in `ST_OFF`, and the period and compare values only outside it. Each accepted period or compare write raises a completion flag a short, prescaler-dependent time later. Software clears these flags through a separate clear register.

Top module: `lpt_timer`

Register addresses (`bus_addr`): 0 control, 1 configuration, 2 period limit, 3 compare A, 4 compare B, 5 channel control, 6 status, 7 flag clear.

## Requirements
- R1: After reset, every register reads 0, the state is `ST_OFF`, both outputs are 0 and all status flags are 0.
- R2: Configuration bits are the prescaler exponent p in bits 2:0 and the global polarity in bit 3. A write to them is accepted only in `ST_OFF`. In any other state the write is ignored and the readback is unchanged.
- R3: Writes to the period limit (address 2) and to compare A and B (addresses 3 and 4) are accepted only while the timer is enabled. In `ST_OFF` they are ignored.
- R4: Control bit 0 is enable and bit 1 is go. In `ST_OFF`, a write with bit 0 set takes `T_ENABLE`, and any go bit in that write is ignored. In `ST_ARMED`, a write with both bits set takes `T_START`. A write with bit 0 clear takes `T_STOP` from any state. Control readback gives bit 0 for enabled and bit 1 for running.
- R5: While running, the counter holds each value for 2^p clocks. The period is (limit+1)·2^p clocks. A channel is active while the count is above its compare value, which gives (limit − compare)·2^p active clocks per period.
- R6: New limit and compare values written while running take effect only at the next wrap from limit to 0.
- R7: Status bit 0 (limit), bit 1 (compare A) and bit 2 (compare B) are set exactly 2^p clocks after the edge that accepts the matching write. An ignored write sets no flag.
- R8: Writing 1 to bit k of the clear register clears status bit k. If the flag is being set in the same cycle, the set wins.
- R9: Channel control bits are: bit 0 enable A, bit 1 polarity A, bit 2 enable B, bit 3 polarity B. A polarity bit is updated only if that channel was disabled before the write. The enable bits are always updated.
- R10: After an accepted channel-control write, further channel-control writes are ignored until 3·2^p clocks have passed. A write exactly 3·2^p edges later is accepted.
- R11: When the timer is not running, or a channel is disabled, that output sits at its polarity bit. `T_STOP` and `T_START` reset the counter and the prescaler to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` |
| pwm_o | output | 2 | Waveform outputs, channel A in bit 0 |

## Verification
In the same cycle, a delayed completion flag can mature while software writes the clear register for that flag. The bench provokes this by issuing a limit write with p = 1 and then writing the clear bit exactly two edges later. It expects the flag to read 1, because the set wins. A behavioural model runs alongside the design and predicts both outputs on every clock. It therefore also judges the case where a compare write lands while the counter is partway through a period, and the old compare must keep driving the output until the wrap.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } lpt_state_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_CFG  = 3'd1;
    localparam logic [2:0] A_PER  = 3'd2;
    localparam logic [2:0] A_CMPA = 3'd3;
    localparam logic [2:0] A_CMPB = 3'd4;
    localparam logic [2:0] A_CHC  = 3'd5;
    localparam logic [2:0] A_STAT = 3'd6;
    localparam logic [2:0] A_CLR  = 3'd7;

endpackage

// File: rtl/lpt_counter.sv
module lpt_counter #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 3,
    parameter int NCH   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run_i,
    input  logic                       load_i,
    input  logic [PSC_W-1:0]           psc_i,
    input  logic [CNT_W-1:0]           lim_sh_i,
    input  logic [NCH-1:0][CNT_W-1:0]  cmp_sh_i,
    output logic [CNT_W-1:0]           cnt_o,
    output logic [NCH-1:0][CNT_W-1:0]  cmp_act_o
);
    localparam int RATIO_W = 1 << PSC_W;
    localparam int PRE_W   = RATIO_W - 1;

    logic [RATIO_W-1:0]          ratio;
    logic [PRE_W-1:0]            pre_lim;
    logic [PRE_W-1:0]            pre_q;
    logic [CNT_W-1:0]            cnt_q;
    logic [CNT_W-1:0]            lim_act_q;
    logic [NCH-1:0][CNT_W-1:0]   cmp_act_q;

    always_comb begin
        ratio   = RATIO_W'(1) << psc_i;
        pre_lim = PRE_W'(ratio - RATIO_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q     <= '0;
            cnt_q     <= '0;
            lim_act_q <= '0;
            cmp_act_q <= '0;
        end else if (!run_i || load_i) begin
            pre_q <= '0;
            cnt_q <= '0;
            if (load_i) begin
                lim_act_q <= lim_sh_i;
                cmp_act_q <= cmp_sh_i;
            end
        end else if (pre_q == pre_lim) begin
            pre_q <= '0;
            if (cnt_q == lim_act_q) begin
                cnt_q     <= '0;
                lim_act_q <= lim_sh_i;
                cmp_act_q <= cmp_sh_i;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    assign cnt_o     = cnt_q;
    assign cmp_act_o = cmp_act_q;
endmodule

// File: rtl/lpt_okflag.sv
module lpt_okflag #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             clr_i,
    output logic             flag_o
);
    logic [DLY_W-1:0] dly_q;
    logic             flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (arm_i) begin
                dly_q <= dly_i;
            end else if (dly_q != '0) begin
                dly_q <= dly_q - DLY_W'(1);
            end
            if (dly_q == DLY_W'(1)) begin
                flag_q <= 1'b1;
            end else if (clr_i) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/lpt_chan.sv
module lpt_chan #(
    parameter int CNT_W = 16
) (
    input  logic             run_i,
    input  logic             en_i,
    input  logic             pol_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             pwm_o
);
    logic active;

    always_comb begin
        active = run_i && en_i && (cnt_i > cmp_i);
        pwm_o  = active ^ pol_i;
    end
endmodule

// File: rtl/lpt_timer.sv
module lpt_timer
    import lpt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 3,
    parameter bit TWO_CH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic [1:0]       pwm_o
);
    localparam int NCH     = 2;
    localparam int NFLAG   = 3;
    localparam int RATIO_W = 1 << PSC_W;
    localparam int LOCK_W  = RATIO_W + 2;

    lpt_state_e                 state_q, state_d;
    logic                       t_start;
    logic                       is_on, is_run, cnt_run;

    logic [PSC_W-1:0]           psc_q;
    logic                       gpol_q;
    logic [CNT_W-1:0]           arr_sh_q;
    logic [NCH-1:0][CNT_W-1:0]  cmp_sh_q;
    logic [NCH-1:0]             chen_q, pol_q;
    logic [NCH-1:0]             chen_eff, pol_eff;
    logic [LOCK_W-1:0]          lock_q;

    logic wr_ctrl, wr_cfg, wr_per, wr_cmpa, wr_cmpb, wr_chc, wr_clr;
    logic cfg_ok, arr_ok, chc_ok;
    logic [NCH-1:0]             cmp_ok;
    logic [NFLAG-1:0]           ok_arm, flags;

    logic [RATIO_W-1:0]         ratio;
    logic [LOCK_W-1:0]          lock_load;

    logic [CNT_W-1:0]           cnt;
    logic [NCH-1:0][CNT_W-1:0]  cmp_act;

    // ---------------- bus decode ----------------
    always_comb begin
        wr_ctrl = bus_we && (bus_addr == A_CTRL);
        wr_cfg  = bus_we && (bus_addr == A_CFG);
        wr_per  = bus_we && (bus_addr == A_PER);
        wr_cmpa = bus_we && (bus_addr == A_CMPA);
        wr_cmpb = bus_we && (bus_addr == A_CMPB);
        wr_chc  = bus_we && (bus_addr == A_CHC);
        wr_clr  = bus_we && (bus_addr == A_CLR);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        t_start = 1'b0;
        if (wr_ctrl) begin
            unique case (state_q)
                ST_OFF: begin
                    if (bus_wdata[0]) state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (!bus_wdata[0]) begin
                        state_d = ST_OFF;
                    end else if (bus_wdata[1]) begin
                        state_d = ST_RUN;
                        t_start = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!bus_wdata[0]) state_d = ST_OFF;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // ---------------- state outputs ----------------
    always_comb begin
        is_on   = (state_q != ST_OFF);
        is_run  = (state_q == ST_RUN);
        cnt_run = (state_d == ST_RUN);
    end

    // ---------------- write gating ----------------
    always_comb begin
        ratio     = RATIO_W'(1) << psc_q;
        lock_load = LOCK_W'({ratio, 1'b0}) + LOCK_W'(ratio);
        cfg_ok    = wr_cfg && !is_on;
        arr_ok    = wr_per && is_on;
        cmp_ok[0] = wr_cmpa && is_on;
        cmp_ok[1] = wr_cmpb && is_on;
        chc_ok    = TWO_CH && wr_chc && (lock_q <= LOCK_W'(1));
        ok_arm    = {cmp_ok[1], cmp_ok[0], arr_ok};
    end

    // ---------------- register file ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q    <= '0;
            gpol_q   <= 1'b0;
            arr_sh_q <= '0;
            cmp_sh_q <= '0;
            chen_q   <= '0;
            pol_q    <= '0;
            lock_q   <= '0;
        end else begin
            if (cfg_ok) begin
                psc_q  <= bus_wdata[PSC_W-1:0];
                gpol_q <= bus_wdata[PSC_W];
            end
            if (arr_ok) arr_sh_q <= bus_wdata;
            for (int c = 0; c < NCH; c++) begin
                if (cmp_ok[c]) cmp_sh_q[c] <= bus_wdata;
            end
            if (chc_ok) begin
                for (int c = 0; c < NCH; c++) begin
                    chen_q[c] <= bus_wdata[2*c];
                    if (!chen_q[c]) pol_q[c] <= bus_wdata[2*c+1];
                end
                lock_q <= lock_load;
            end else if (lock_q != '0) begin
                lock_q <= lock_q - LOCK_W'(1);
            end
        end
    end

    // ---------------- variant select ----------------
    generate
        if (TWO_CH) begin : g_dual
            assign chen_eff = chen_q;
            assign pol_eff  = pol_q;
        end else begin : g_single
            assign chen_eff = 2'b01;
            assign pol_eff  = {1'b0, gpol_q};
        end
    endgenerate

    // ---------------- counter ----------------
    lpt_counter #(
        .CNT_W (CNT_W),
        .PSC_W (PSC_W),
        .NCH   (NCH)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (cnt_run),
        .load_i    (t_start),
        .psc_i     (psc_q),
        .lim_sh_i  (arr_sh_q),
        .cmp_sh_i  (cmp_sh_q),
        .cnt_o     (cnt),
        .cmp_act_o (cmp_act)
    );

    // ---------------- completion flags ----------------
    generate
        for (genvar k = 0; k < NFLAG; k++) begin : g_ok
            lpt_okflag #(.DLY_W(RATIO_W)) u_ok (
                .clk    (clk),
                .rst_n  (rst_n),
                .arm_i  (ok_arm[k]),
                .dly_i  (ratio),
                .clr_i  (wr_clr && bus_wdata[k]),
                .flag_o (flags[k])
            );
        end
    endgenerate

    // ---------------- outputs ----------------
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            lpt_chan #(.CNT_W(CNT_W)) u_ch (
                .run_i (is_run),
                .en_i  (chen_eff[c]),
                .pol_i (pol_eff[c]),
                .cnt_i (cnt),
                .cmp_i (cmp_act[c]),
                .pwm_o (pwm_o[c])
            );
        end
    endgenerate

    // ---------------- readback ----------------
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: bus_rdata = CNT_W'({is_run, is_on});
            A_CFG:  bus_rdata = CNT_W'({gpol_q, psc_q});
            A_PER:  bus_rdata = arr_sh_q;
            A_CMPA: bus_rdata = cmp_sh_q[0];
            A_CMPB: bus_rdata = cmp_sh_q[1];
            A_CHC:  bus_rdata = CNT_W'({pol_q[1], chen_q[1], pol_q[0], chen_q[0]});
            A_STAT: bus_rdata = CNT_W'(flags);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lpt_timer_chk.sv
module lpt_timer_chk
    import lpt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [2:0]       bus_addr,
    input logic [1:0]       go_bits,
    input lpt_state_e       state_q,
    input logic [PSC_W-1:0] psc_q,
    input logic             gpol_q,
    input logic [CNT_W-1:0] arr_sh_q,
    input logic [1:0]       chen_q,
    input logic [1:0]       pol_q,
    input logic [1:0]       pol_eff,
    input logic [1:0]       pwm_o
);
    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CFG && state_q != ST_OFF) |=> ($stable(psc_q) && $stable(gpol_q)));

    // R3
    per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PER && state_q == ST_OFF) |=> $stable(arr_sh_q));

    // R4
    start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL && state_q == ST_ARMED && go_bits == 2'b11) |=> (state_q == ST_RUN));

    // R4
    off_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL && state_q == ST_OFF) |=> (state_q != ST_RUN));

    // R9
    pol_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CHC && chen_q[0]) |=> $stable(pol_q[0]));

    // R9
    pol_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CHC && chen_q[1]) |=> $stable(pol_q[1]));

    // R11
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> (pwm_o == pol_eff));
endmodule

bind lpt_timer lpt_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .go_bits  (bus_wdata[1:0]),
    .state_q  (state_q),
    .psc_q    (psc_q),
    .gpol_q   (gpol_q),
    .arr_sh_q (arr_sh_q),
    .chen_q   (chen_q),
    .pol_q    (pol_q),
    .pol_eff  (pol_eff),
    .pwm_o    (pwm_o)
);

// File: tb/test_lpt_timer.sv
`timescale 1ns/1ps
module test_lpt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic [1:0]  pwm_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lpt_timer i_lpt_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
    );

    // ---------------- behavioural reference ----------------
    int m_state, m_p, m_gpol, m_lim, m_lim_a, m_pre, m_cnt, m_lock;
    int m_cmp[2], m_cmp_a[2], m_chen[2], m_pol[2];
    int m_dly[3], m_flag[3];

    task automatic model_step();
        int n_state, n_pre, n_cnt, n_lim_a, n_lock;
        int n_cmp_a[2], n_dly[3], n_flag[3];
        int w;
        if (!rst_n) begin
            m_state = 0; m_p = 0; m_gpol = 0; m_lim = 0; m_lim_a = 0;
            m_pre = 0; m_cnt = 0; m_lock = 0;
            for (int i = 0; i < 2; i++) begin
                m_cmp[i] = 0; m_cmp_a[i] = 0; m_chen[i] = 0; m_pol[i] = 0;
            end
            for (int k = 0; k < 3; k++) begin m_dly[k] = 0; m_flag[k] = 0; end
            return;
        end
        w = int'(bus_wdata);
        n_state = m_state; n_pre = m_pre; n_cnt = m_cnt; n_lim_a = m_lim_a;
        n_cmp_a = m_cmp_a;
        n_lock = (m_lock != 0) ? m_lock - 1 : 0;
        for (int k = 0; k < 3; k++) begin
            n_dly[k]  = (m_dly[k] != 0) ? m_dly[k] - 1 : 0;
            n_flag[k] = (m_dly[k] == 1) ? 1 : m_flag[k];
        end
        if (m_state == 2) begin
            if (m_pre == (1 << m_p) - 1) begin
                n_pre = 0;
                if (m_cnt == m_lim_a) begin
                    n_cnt = 0; n_lim_a = m_lim; n_cmp_a = m_cmp;
                end else n_cnt = m_cnt + 1;
            end else n_pre = m_pre + 1;
        end
        if (bus_we) begin
            case (bus_addr)
                3'd0: begin
                    if ((w & 1) == 0) begin
                        n_state = 0; n_pre = 0; n_cnt = 0;
                    end else if (m_state == 0) n_state = 1;
                    else if (m_state == 1 && (w & 2) != 0) begin
                        n_state = 2; n_pre = 0; n_cnt = 0;
                        n_lim_a = m_lim; n_cmp_a = m_cmp;
                    end
                end
                3'd1: if (m_state == 0) begin m_p = w & 7; m_gpol = (w >> 3) & 1; end
                3'd2: if (m_state != 0) begin m_lim = w; n_dly[0] = 1 << m_p; end
                3'd3: if (m_state != 0) begin m_cmp[0] = w; n_dly[1] = 1 << m_p; end
                3'd4: if (m_state != 0) begin m_cmp[1] = w; n_dly[2] = 1 << m_p; end
                3'd5: if (m_lock <= 1) begin
                    for (int i = 0; i < 2; i++) begin
                        if (m_chen[i] == 0) m_pol[i] = (w >> (2*i+1)) & 1;
                        m_chen[i] = (w >> (2*i)) & 1;
                    end
                    n_lock = 3 * (1 << m_p);
                end
                3'd7: for (int k = 0; k < 3; k++)
                    if (((w >> k) & 1) != 0 && m_dly[k] != 1) n_flag[k] = 0;
                default: ;
            endcase
        end
        m_state = n_state; m_pre = n_pre; m_cnt = n_cnt; m_lim_a = n_lim_a;
        m_cmp_a = n_cmp_a; m_lock = n_lock; m_dly = n_dly; m_flag = n_flag;
    endtask

    function automatic logic [1:0] model_pwm();
        logic [1:0] r;
        for (int i = 0; i < 2; i++)
            r[i] = ((m_state == 2 && m_chen[i] != 0 && m_cnt > m_cmp_a[i]) ? 1'b1 : 1'b0)
                   ^ m_pol[i][0];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // every clock: R5 R6 R11 waveform against the model
    always @(posedge clk) begin
        logic [1:0] e;
        model_step();
        #2;
        e = model_pwm();
        chk(pwm_o === e, "R5 R6 R11 per-clock pwm", int'(pwm_o), int'(e));
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input int exp, input string tag);
        bus_addr = a;
        #1;
        chk(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
    endtask

    task automatic duty(input int exp, input string tag);
        int hi = 0;
        repeat (10) begin
            @(posedge clk); #2;
            if (pwm_o[0]) hi++;
        end
        chk(hi == exp, tag, hi, exp);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pwm_o === 2'b00, "R1 reset pwm", int'(pwm_o), 0);
        rd(3'd0, 0, "R1 reset ctrl");
        rd(3'd1, 0, "R1 reset cfg");
        rd(3'd6, 0, "R1 reset status");
        // R3 limit write ignored while off, no flag (R7)
        wr(3'd2, 16'd9);
        rd(3'd2, 0, "R3 limit ignored when off");
        repeat (3) @(negedge clk);
        rd(3'd6, 0, "R7 no flag for ignored write");
        // R2 config accepted while off, p=1
        wr(3'd1, 16'd1);
        rd(3'd1, 1, "R2 cfg accepted when off");
        // R4 go ignored from off
        wr(3'd0, 16'd3);
        rd(3'd0, 1, "R4 go ignored from off");
        // R2 config ignored while enabled
        wr(3'd1, 16'd5);
        rd(3'd1, 1, "R2 cfg ignored when enabled");
        // R7 flag timing with p=1
        wr(3'd2, 16'd4);
        rd(3'd6, 0, "R7 flag not yet set +0");
        @(negedge clk);
        rd(3'd6, 0, "R7 flag not yet set +1");
        @(negedge clk);
        rd(3'd6, 1, "R7 flag set after 2^p");
        wr(3'd3, 16'd1);
        wr(3'd4, 16'd3);
        rd(3'd3, 1, "R3 compare A accepted when enabled");
        // R10 lockout, ratio 2 -> 6 cycles
        wr(3'd5, 16'd13);
        rd(3'd5, 13, "R10 first chctl accepted");
        wr(3'd5, 16'd0);
        rd(3'd5, 13, "R10 chctl ignored during lockout");
        repeat (3) @(negedge clk);
        wr(3'd5, 16'd0);
        rd(3'd5, 13, "R10 chctl ignored one edge early");
        wr(3'd5, 16'd11);
        rd(3'd5, 9, "R9 R10 accepted at 3*2^p, held polarity");
        chk(pwm_o === 2'b10, "R11 outputs idle at polarity", int'(pwm_o), 2);
        // R4 start
        wr(3'd0, 16'd3);
        rd(3'd0, 3, "R4 start from armed");
        duty(6, "R5 active clocks per period");
        // R6 new compare at wrap
        wr(3'd3, 16'd3);
        repeat (10) @(negedge clk);
        duty(2, "R6 new compare after wrap");
        // R8 clear
        rd(3'd6, 7, "R7 all flags set");
        wr(3'd7, 16'd7);
        rd(3'd6, 0, "R8 flags cleared");
        // R8 set and clear in same cycle
        wr(3'd2, 16'd4);
        @(negedge clk);
        wr(3'd7, 16'd1);
        rd(3'd6, 1, "R8 set wins over clear");
        wr(3'd7, 16'd1);
        rd(3'd6, 0, "R8 clear after collision");
        // R11 stop
        wr(3'd0, 16'd0);
        rd(3'd0, 0, "R4 stop");
        chk(pwm_o === 2'b10, "R11 stopped outputs at polarity", int'(pwm_o), 2);
        wr(3'd2, 16'd7);
        rd(3'd2, 4, "R3 limit ignored after stop");
        repeat (4) @(negedge clk);
        rd(3'd6, 0, "R7 no flag after ignored write");
        wr(3'd1, 16'd10);
        rd(3'd1, 10, "R2 cfg accepted after stop");
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule